// File: doc/BRIEF.md
# Round-Robin Central Bus Arbiter with Parking

This block is the central arbiter of a shared parallel bus with several masters. Each master owns a dedicated active-low request line into the arbiter and a dedicated active-low grant line out of it. The arbiter watches the bus framing and initiator-ready lines, both active low, to tell when the bus is idle. While a transaction is still in progress it chooses the next owner in round-robin order, so the grant is already in place when the bus goes idle. When no request is pending and the bus is idle, the grant stays on the master that most recently started a transaction. That master can then begin a new transaction without first raising a request.

A two-state machine drives the grants. In **ST_GRANT**, exactly one grant is driven, to the master held in the grant index register. In **ST_SWITCH**, no grant is driven for one clock. There are three transitions:

- **hold**: ST_GRANT to ST_GRANT, taken when the chosen target equals the current holder.
- **release**: ST_GRANT to ST_SWITCH, taken when the target differs. The grant index is loaded with the target on this transition.
- **regrant**: ST_SWITCH to ST_GRANT, always taken after one cycle.

The target is chosen in this order:

- the first requester found by a round-robin search that starts at the master after the last owner;
- if nobody requests and the bus is busy, the current holder;
- if nobody requests and the bus is idle, the last owner.

Top module: `bus_arbiter`

## Requirements
- R1: Bit i of `req_n` low means master i requests the bus, and bit i of `gnt_n` low means master i is granted. While `rst_n` is low, and after reset until a request arrives, `gnt_n` equals all ones except bit 0, which is low.
- R2: At most one bit of `gnt_n` is low in any cycle.
- R3: When the grant moves from one master to another, it passes through exactly one cycle with every `gnt_n` bit high. The grant never jumps directly from one master to another.
- R4: For any set of requesters, the next grant goes to the first requester among masters owner+1, owner+2, … taken modulo N. When that requester differs from the holder, the grant shows the gap in the first cycle after the request is applied and shows the new holder in the second cycle.
- R5: If the last owner and another master both request, the other master is granted, even though the last owner is requesting again.
- R6: Arbitration runs while the bus is busy. With `frame_n` low, a new request moves the grant within two cycles.
- R7: If no request is pending and the bus is busy (`frame_n` or `irdy_n` low), the grant stays where it is.
- R8: If no request is pending and the bus is idle (`frame_n` and `irdy_n` both high), the grant parks on the last owner. This holds even when the grant had gone to a master that never started a transaction.
- R9: The owner is recorded in the first cycle `frame_n` is low after a cycle in which `frame_n` and `irdy_n` were both high, provided a grant is driven in that cycle. The master holding that grant becomes the owner.
- R10: The parked master may start a transaction with no request asserted. Its grant stays asserted with no gap through the start of that transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | N_MASTERS | Per-master request, active low |
| frame_n | input | 1 | Bus framing line, active low |
| irdy_n | input | 1 | Initiator-ready line, active low |
| gnt_n | output | N_MASTERS | Per-master grant, active low |

## Verification
Recording a new owner and choosing the next grant can fall on the same clock edge. At that edge the round-robin search still uses the previous owner, while the owner register takes the master that has just started. The bench provokes this by having a granted master lower `frame_n` in the same cycle that a different master raises its request. It then judges the result twice. First, the grant must move to the requester with a one-cycle gap. Second, once the bus goes idle with no requests, the grant must park on the master that started the transaction, not on the earlier owner. A sweep over every owner and every request pattern checks the round-robin order arithmetically.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [0:0] {
        ST_GRANT  = 1'b0,
        ST_SWITCH = 1'b1
    } arb_state_t;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Walk from the farthest candidate to the nearest so the nearest wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N; k >= 1; k--) begin
            int          c;
            logic [IW-1:0] ci;
            c = int'(ptr) + k;
            if (c >= N) c = c - N;
            ci = IW'(c);
            if (req[ci]) begin
                found = 1'b1;
                idx   = ci;
            end
        end
    end

endmodule

// File: rtl/arb_owner_track.sv
module arb_owner_track #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_n,
    input  logic          irdy_n,
    input  logic          gnt_valid,
    input  logic [IW-1:0] gnt_idx,
    output logic [IW-1:0] owner
);

    logic idle_q;
    logic start;

    assign start = !frame_n && idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= 1'b1;
            owner  <= '0;
        end else begin
            idle_q <= frame_n && irdy_n;
            if (start && gnt_valid)
                owner <= gnt_idx;
        end
    end

    // R9: the owner only changes on a transaction start under a grant
    assert_owner_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(owner) |-> $past(start && gnt_valid));

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
    parameter int N_MASTERS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_n,
    input  logic                 frame_n,
    input  logic                 irdy_n,
    output logic [N_MASTERS-1:0] gnt_n
);
    import arb_pkg::*;

    localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

    arb_state_t    state, state_nx;
    logic [IW-1:0] gnt_idx, gnt_idx_nx;
    logic [IW-1:0] owner;
    logic [IW-1:0] pick_idx;
    logic [IW-1:0] target;
    logic          pick_found;
    logic          bus_idle;
    logic [N_MASTERS-1:0] reqv;
    logic [N_MASTERS-1:0] gvec;

    assign reqv     = ~req_n;
    assign bus_idle = frame_n && irdy_n;

    arb_rr_pick #(.N(N_MASTERS), .IW(IW)) u_pick (
        .req   (reqv),
        .ptr   (owner),
        .found (pick_found),
        .idx   (pick_idx)
    );

    arb_owner_track #(.N(N_MASTERS), .IW(IW)) u_owner (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .gnt_valid (state == ST_GRANT),
        .gnt_idx   (gnt_idx),
        .owner     (owner)
    );

    // Target selection and next state
    always_comb begin
        if (pick_found)    target = pick_idx;
        else if (bus_idle) target = owner;
        else               target = gnt_idx;

        state_nx   = state;
        gnt_idx_nx = gnt_idx;
        unique case (state)
            ST_GRANT: begin
                if (target != gnt_idx) begin
                    state_nx   = ST_SWITCH;
                    gnt_idx_nx = target;
                end
            end
            ST_SWITCH: begin
                state_nx = ST_GRANT;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_GRANT;
            gnt_idx <= '0;
        end else begin
            state   <= state_nx;
            gnt_idx <= gnt_idx_nx;
        end
    end

    // Outputs
    always_comb begin
        for (int i = 0; i < N_MASTERS; i++)
            gnt_n[i] = !((state == ST_GRANT) && (gnt_idx == IW'(i)));
    end

    assign gvec = ~gnt_n;

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gvec) <= 1);

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gvec) && (|$past(gvec))) |-> (gvec == $past(gvec)));

    assert_gap_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gvec == '0) |=> (gvec != '0));

    assert_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_idle && (reqv == '0) && (|gvec)) |=> $stable(gvec));

    assert_park_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle && (reqv == '0) && (state == ST_GRANT) && (gnt_idx == owner))
        |=> $stable(gvec));

endmodule

// File: tb/bus_arbiter_tb.sv
module bus_arbiter_tb;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] req_n;
    logic         frame_n;
    logic         irdy_n;
    logic [N-1:0] gnt_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bus_arbiter #(.N_MASTERS(N)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n   (req_n),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .gnt_n   (gnt_n)
    );

    function automatic logic [N-1:0] gv(input int m);
        return ~(N'(1) << m);
    endfunction

    function automatic int rr_next(input int o, input logic [N-1:0] p);
        for (int k = 1; k <= N; k++) begin
            if (p[(o + k) % N]) return (o + k) % N;
        end
        return o;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] exp);
        checks++;
        if (gnt_n !== exp) begin
            failures++;
            $display("FAIL %s gnt_n actual=%b expected=%b", tag, gnt_n, exp);
        end
    endtask

    // Request master m, let it start a one-cycle transaction, then release
    task automatic own(input int m);
        req_n = gv(m);
        repeat (4) @(negedge clk);
        chk("R4 own grant", gv(m));
        frame_n = 1'b0;
        req_n   = '1;
        @(negedge clk);
        frame_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        rst_n   = 1'b0;
        req_n   = '1;
        frame_n = 1'b1;
        irdy_n  = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 in reset", 4'b1110);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 after reset", 4'b1110);

        // R4/R3 sweep over every owner and request pattern
        for (int o = 0; o < N; o++) begin
            for (int p = 1; p < (1 << N); p++) begin
                int t;
                own(o);
                t = rr_next(o, N'(p));
                req_n = ~N'(p);
                @(negedge clk);
                if (t != o) chk("R3 gap", '1);
                else        chk("R4 stay", gv(o));
                @(negedge clk);
                chk("R4 rr target", gv(t));
                req_n = '1;
            end
        end

        // R5: last owner re-requests together with another master
        own(1);
        req_n = 4'b1001;
        @(negedge clk);
        chk("R5 gap", '1);
        @(negedge clk);
        chk("R5 other master first", gv(2));
        req_n = '1;

        // R10, R6, R7, R8
        own(0);
        repeat (3) @(negedge clk);
        chk("R8 parked on 0", gv(0));
        frame_n = 1'b0;
        irdy_n  = 1'b0;
        @(negedge clk);
        chk("R10 parked start keeps grant", gv(0));
        req_n = 4'b1011;
        @(negedge clk);
        chk("R6 gap while busy", '1);
        @(negedge clk);
        chk("R6 grant moved while busy", gv(2));
        req_n = '1;
        repeat (2) @(negedge clk);
        chk("R7 hold while busy", gv(2));
        frame_n = 1'b1;
        @(negedge clk);
        chk("R7 hold irdy busy", gv(2));
        irdy_n = 1'b1;
        @(negedge clk);
        chk("R8 gap before park", '1);
        @(negedge clk);
        chk("R8 park on last owner", gv(0));

        // R9 collision: owner recorded on the edge the grant moves
        req_n = 4'b1011;
        repeat (3) @(negedge clk);
        chk("R4 grant to 2", gv(2));
        frame_n = 1'b0;
        req_n   = 4'b1101;
        @(negedge clk);
        chk("R9 gap same edge", '1);
        @(negedge clk);
        chk("R9 grant to 1", gv(1));
        frame_n = 1'b1;
        req_n   = '1;
        @(negedge clk);
        chk("R9 gap before park", '1);
        @(negedge clk);
        chk("R9 park on new owner 2", gv(2));
        repeat (2) @(negedge clk);
        chk("R2 single parked grant", gv(2));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule